// File: doc/BRIEF.md
# Three-Mode Interrupt Response Sequencer

This block sits beside a small processor datapath and decides what happens when a maskable interrupt request is taken. It holds an interrupt-enable flag and a response mode, both set by commands from the instruction decoder. At an instruction boundary with interrupts enabled and the request high, it takes the interrupt. It then runs a one-cycle acknowledge strobe, during which the interrupting device drives a byte. What follows depends on the mode.

In mode 0 the device byte is handed back to the decoder as the next opcode to execute. In mode 1 the device byte is ignored: the old program counter is pushed and execution restarts at a fixed address. In mode 2 the old program counter is pushed, then a 16-bit service address is fetched from a table in memory. The table entry's address has the captured base register as its high byte and the even-aligned device byte as its low byte. The fetched word becomes the new program counter.

The program counter, stack pointer, base register and mode are all captured when the interrupt is taken. Later changes on those inputs do not disturb a sequence that is already running.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset the mode is 0 (`mode_o`=0), interrupts are disabled (`ie_o`=0), and none of `ack_o`, `push_req_o`, `mem_rd_o`, `pc_load_o` or `opcode_valid_o` is high.
- R2: A `mode_wr` pulse with `mode_sel` 0, 1 or 2 sets `mode_o` to that value on the next clock. A write of 3 leaves the mode unchanged. `ie_set` sets `ie_o` and `ie_clr` clears it, with the clear taking priority.
- R3: The block is idle when it is not running a sequence. While idle, a request is taken only on a clock edge where `ie_o`, `irq_req` and `insn_bnd` are all high. `ack_o` is then high for exactly the following cycle, and `ack_data` is sampled at the end of that cycle.
- R4: Taking a request clears `ie_o`, and this overrides an `ie_set` on the same edge. No further acknowledge occurs until `ie_o` is set again, even if `irq_req` stays high.
- R5: In mode 0, the cycle after the acknowledge raises `opcode_valid_o` for one cycle with `opcode_o` equal to the device byte. No push and no program-counter load take place.
- R6: In modes 1 and 2 the captured program counter is pushed as two bytes. The high byte goes to address SP-1 and then the low byte to SP-2, where SP is the stack pointer captured at the take. Each push request holds its address and data until `push_ack` is seen high at a clock edge.
- R7: In mode 1, after the two pushes, `pc_load_o` is high for one cycle with `pc_val_o` = 0x0038, whatever byte the device supplied.
- R8: In mode 2, after the pushes, two reads are issued on consecutive cycles. The first is at T = {I, device byte with bit 0 forced to 0} and the second at T+1. Read data is expected on `mem_rdata` in the cycle after each read. `pc_load_o` then carries `pc_val_o` = {byte read from T+1, byte read from T}.
- R9: Mode, I, PC and SP are captured at the take. Changing `mode_sel`/`mode_wr`, `i_reg`, `pc_cur` or `sp_cur` during a running sequence does not alter its pushes, reads or loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-select command strobe |
| mode_sel | input | 2 | Mode value for the command |
| ie_set | input | 1 | Enable-interrupts command |
| ie_clr | input | 1 | Disable-interrupts command |
| ie_o | output | 1 | Current interrupt-enable flag |
| mode_o | output | 2 | Current response mode |
| irq_req | input | 1 | Maskable interrupt request, level |
| insn_bnd | input | 1 | High when the datapath is at an instruction boundary |
| ack_o | output | 1 | Acknowledge strobe to the device |
| ack_data | input | 8 | Byte from the device during acknowledge |
| i_reg | input | 8 | Vector base register value |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 16 | Current stack pointer |
| mem_rd_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| push_req_o | output | 1 | Stack byte write request |
| push_ack | input | 1 | Datapath accepted the stack write |
| push_addr_o | output | 16 | Stack write address |
| push_data_o | output | 8 | Stack write byte |
| pc_load_o | output | 1 | Load program counter strobe |
| pc_val_o | output | 16 | New program counter value |
| opcode_valid_o | output | 1 | Device-supplied opcode strobe |
| opcode_o | output | 8 | Device-supplied opcode |

## Verification
The bench builds the block with its default 8-bit data width, which gives a 16-bit address and the fixed restart address 0x0038. At this size every one of the 256 device bytes can be sent through mode 2, paired with a varying base register, program counter and stack pointer. This exercises table alignment for odd bytes and the T/T+1 pairing across every low-byte value. Push acknowledge delays of zero to two cycles, mode and enable commands, the gating inputs and a mid-sequence change of every captured input are covered around those sweeps.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    IM_OPC = 2'd0,
    IM_RST = 2'd1,
    IM_VEC = 2'd2
  } im_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_OPC, S_PSH_H, S_PSH_L, S_RD_L, S_RD_H, S_WT_H, S_LOAD
  } seq_st_e;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  input  logic       ie_set,
  input  logic       ie_clr,
  input  logic       take,
  output im_e        mode_q,
  output logic       ie_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= IM_OPC;
      ie_q   <= 1'b0;
    end else begin
      if (mode_wr && mode_sel != 2'd3) mode_q <= im_e'(mode_sel);
      if (take)        ie_q <= 1'b0;
      else if (ie_clr) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ie,
  input  logic    irq_req,
  input  logic    insn_bnd,
  input  logic    push_ack,
  input  im_e     seq_mode,
  output logic    take,
  output seq_st_e state
);
  seq_st_e nxt;

  assign take = (state == S_IDLE) && ie && irq_req && insn_bnd;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (take) nxt = S_ACK;
      S_ACK:   nxt = (seq_mode == IM_OPC) ? S_OPC : S_PSH_H;
      S_OPC:   nxt = S_IDLE;
      S_PSH_H: if (push_ack) nxt = S_PSH_L;
      S_PSH_L: if (push_ack) nxt = (seq_mode == IM_RST) ? S_LOAD : S_RD_L;
      S_RD_L:  nxt = S_RD_H;
      S_RD_H:  nxt = S_WT_H;
      S_WT_H:  nxt = S_LOAD;
      S_LOAD:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int RST_VEC = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  seq_st_e           state,
  input  im_e               mode_in,
  input  logic [DATA_W-1:0] i_reg,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] sp_cur,
  input  logic [DATA_W-1:0] ack_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output im_e               seq_mode,
  output logic [ADDR_W-1:0] push_addr,
  output logic [DATA_W-1:0] push_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc_val,
  output logic [DATA_W-1:0] opcode
);
  localparam logic [ADDR_W-1:0] RV = ADDR_W'(RST_VEC);

  function automatic logic [ADDR_W-1:0] tbl_addr(input logic [DATA_W-1:0] base,
                                                 input logic [DATA_W-1:0] dev);
    return {base, dev[DATA_W-1:1], 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] stack_slot(input logic [ADDR_W-1:0] sp,
                                                   input logic [1:0] k);
    return sp - ADDR_W'(k);
  endfunction

  logic [DATA_W-1:0] i_q, dev_q, lo_q, hi_q;
  logic [ADDR_W-1:0] pc_q, sp_q;
  logic [ADDR_W-1:0] tbl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_mode <= IM_OPC;
      i_q <= '0; dev_q <= '0; lo_q <= '0; hi_q <= '0;
      pc_q <= '0; sp_q <= '0;
    end else begin
      if (take) begin
        seq_mode <= mode_in;
        i_q      <= i_reg;
        pc_q     <= pc_cur;
        sp_q     <= sp_cur;
      end
      if (state == S_ACK)  dev_q <= ack_data;
      if (state == S_RD_H) lo_q  <= mem_rdata;
      if (state == S_WT_H) hi_q  <= mem_rdata;
    end
  end

  assign tbl       = tbl_addr(i_q, dev_q);
  assign mem_addr  = (state == S_RD_H) ? tbl + ADDR_W'(1) : tbl;
  assign push_addr = stack_slot(sp_q, (state == S_PSH_H) ? 2'd1 : 2'd2);
  assign push_data = (state == S_PSH_H) ? pc_q[ADDR_W-1:DATA_W] : pc_q[DATA_W-1:0];
  assign pc_val    = (seq_mode == IM_RST) ? RV : {hi_q, lo_q};
  assign opcode    = dev_q;
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter int RST_VEC = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic              ie_set,
  input  logic              ie_clr,
  output logic              ie_o,
  output logic [1:0]        mode_o,
  input  logic              irq_req,
  input  logic              insn_bnd,
  output logic              ack_o,
  input  logic [DATA_W-1:0] ack_data,
  input  logic [DATA_W-1:0] i_reg,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] sp_cur,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              push_req_o,
  input  logic              push_ack,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_val_o,
  output logic              opcode_valid_o,
  output logic [DATA_W-1:0] opcode_o
);
  im_e     mode_q, seq_mode;
  logic    take;
  seq_st_e state;

  irq_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .ie_set(ie_set), .ie_clr(ie_clr), .take(take),
    .mode_q(mode_q), .ie_q(ie_o)
  );

  irq_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ie(ie_o), .irq_req(irq_req),
    .insn_bnd(insn_bnd), .push_ack(push_ack), .seq_mode(seq_mode),
    .take(take), .state(state)
  );

  irq_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)) u_dp (
    .clk(clk), .rst_n(rst_n), .take(take), .state(state), .mode_in(mode_q),
    .i_reg(i_reg), .pc_cur(pc_cur), .sp_cur(sp_cur), .ack_data(ack_data),
    .mem_rdata(mem_rdata), .seq_mode(seq_mode), .push_addr(push_addr_o),
    .push_data(push_data_o), .mem_addr(mem_addr_o), .pc_val(pc_val_o),
    .opcode(opcode_o)
  );

  assign mode_o         = mode_q;
  assign ack_o          = (state == S_ACK);
  assign opcode_valid_o = (state == S_OPC);
  assign push_req_o     = (state == S_PSH_H) || (state == S_PSH_L);
  assign mem_rd_o       = (state == S_RD_L) || (state == S_RD_H);
  assign pc_load_o      = (state == S_LOAD);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ie_o,
  input logic              irq_req,
  input logic              insn_bnd,
  input logic              ack_o,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              push_req_o,
  input logic              push_ack,
  input logic [ADDR_W-1:0] push_addr_o,
  input logic [DATA_W-1:0] push_data_o,
  input logic              pc_load_o,
  input logic              opcode_valid_o
);
  // R3: an acknowledge follows an edge with enable, request and boundary high
  a_r3_take_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(ie_o && irq_req && insn_bnd));

  // R4: enable is already clear while the acknowledge runs
  a_r4_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !ie_o);

  // R5: at most one sequencer strobe at a time
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, opcode_valid_o, push_req_o, mem_rd_o, pc_load_o}));

  // R6: an unaccepted push holds its address and data
  a_r6_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o && !push_ack |=> push_req_o && $stable(push_addr_o) && $stable(push_data_o));

  // R8: first table read is word aligned
  a_r8_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o && !$past(mem_rd_o) |-> !mem_addr_o[0]);

  // R8: second read follows at the next address
  a_r8_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o && $past(mem_rd_o) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));
endmodule

bind irq_resp_seq irq_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ie_o(ie_o), .irq_req(irq_req), .insn_bnd(insn_bnd),
  .ack_o(ack_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .push_req_o(push_req_o), .push_ack(push_ack), .push_addr_o(push_addr_o),
  .push_data_o(push_data_o), .pc_load_o(pc_load_o), .opcode_valid_o(opcode_valid_o)
);

// File: tb/test_irq_resp_seq.sv
module test_irq_resp_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, ie_set = 0, ie_clr = 0, irq_req = 0, insn_bnd = 1;
  logic [1:0] mode_sel = 0;
  logic [7:0] ack_data = 0, i_reg = 0, mem_rdata = 0;
  logic [15:0] pc_cur = 0, sp_cur = 0;
  logic push_ack = 0;
  logic ie_o, ack_o, mem_rd_o, push_req_o, pc_load_o, opcode_valid_o;
  logic [1:0] mode_o;
  logic [15:0] mem_addr_o, push_addr_o, pc_val_o;
  logic [7:0] push_data_o, opcode_o;

  irq_resp_seq i_irq_resp_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .ie_set(ie_set), .ie_clr(ie_clr), .ie_o(ie_o), .mode_o(mode_o),
    .irq_req(irq_req), .insn_bnd(insn_bnd), .ack_o(ack_o), .ack_data(ack_data),
    .i_reg(i_reg), .pc_cur(pc_cur), .sp_cur(sp_cur), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rdata(mem_rdata), .push_req_o(push_req_o),
    .push_ack(push_ack), .push_addr_o(push_addr_o), .push_data_o(push_data_o),
    .pc_load_o(pc_load_o), .pc_val_o(pc_val_o), .opcode_valid_o(opcode_valid_o),
    .opcode_o(opcode_o)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int stall = 0, stall_cnt = 0;
  int npush = 0, nrd = 0, nack = 0;
  logic [15:0] push_a [4];
  logic [7:0]  push_d [4];
  logic [15:0] rd_a [4];
  bit opc_seen = 0, ld_seen = 0;
  logic [7:0] opc_val;
  logic [15:0] ld_val;
  logic [7:0] rd_pend = 0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // observation and device models, all at the falling edge
  always @(negedge clk) begin
    mem_rdata <= rd_pend;
    if (mem_rd_o) begin
      rd_pend <= memf(mem_addr_o);
      if (nrd < 4) rd_a[nrd] = mem_addr_o;
      nrd++;
    end
    if (ack_o) nack++;
    if (opcode_valid_o) begin opc_seen = 1; opc_val = opcode_o; end
    if (pc_load_o) begin ld_seen = 1; ld_val = pc_val_o; end
    if (push_ack) push_ack <= 1'b0;
    else if (push_req_o) begin
      if (stall_cnt >= stall) begin
        push_ack <= 1'b1;
        stall_cnt = 0;
        if (npush < 4) begin push_a[npush] = push_addr_o; push_d[npush] = push_data_o; end
        npush++;
      end else stall_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clr_log();
    npush = 0; nrd = 0; nack = 0; opc_seen = 0; ld_seen = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_sel = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic enable();
    @(negedge clk); ie_set = 1;
    @(negedge clk); ie_set = 0;
  endtask

  // one interrupt; scr scrambles the captured inputs after the acknowledge
  task automatic run_irq(input logic [1:0] m, input logic [7:0] dev, input logic [7:0] iv,
                         input logic [15:0] pc, input logic [15:0] sp, input int stl,
                         input bit scr);
    bit did = 0;
    bit done = 0;
    logic [15:0] t;
    set_mode(m);
    enable();
    clr_log();
    @(negedge clk);
    stall = stl; ack_data = dev; i_reg = iv; pc_cur = pc; sp_cur = sp; irq_req = 1;
    for (int c = 0; c < 60; c++) begin
      @(posedge clk);
      if (ld_seen || opc_seen) begin done = 1; break; end
      if (scr && nack != 0 && !did) begin
        @(negedge clk);
        i_reg = ~iv; pc_cur = ~pc; sp_cur = sp ^ 16'h0F0F; ack_data = ~dev;
        mode_wr = 1; mode_sel = (m == 2'd1) ? 2'd2 : 2'd1;
        @(negedge clk); mode_wr = 0;
        did = 1;
      end
    end
    @(negedge clk); irq_req = 0;
    repeat (4) @(negedge clk);
    chk(done, "R3 sequence completes", 32'(done), 1);
    chk(nack == 1, "R3 single acknowledge", nack, 1);
    chk(ie_o == 0, "R4 enable cleared by take", ie_o, 0);
    if (m == 2'd0) begin
      chk(opc_seen && opc_val == dev, "R5 opcode equals device byte", opc_val, dev);
      chk(npush == 0 && !ld_seen, "R5 no push or load", npush + 32'(ld_seen), 0);
    end else begin
      chk(npush == 2, "R6 two pushes", npush, 2);
      chk(push_a[0] == sp - 16'd1 && push_d[0] == pc[15:8], "R6 high byte at SP-1",
          {push_a[0], push_d[0]}, {sp - 16'd1, pc[15:8]});
      chk(push_a[1] == sp - 16'd2 && push_d[1] == pc[7:0], "R6 low byte at SP-2",
          {push_a[1], push_d[1]}, {sp - 16'd2, pc[7:0]});
      if (m == 2'd1) begin
        chk(ld_seen && ld_val == 16'h0038, "R7 restart address", ld_val, 16'h0038);
        chk(nrd == 0, "R7 no table read", nrd, 0);
      end else begin
        t = {iv, dev & 8'hFE};
        chk(nrd == 2, "R8 two table reads", nrd, 2);
        chk(rd_a[0] == t && rd_a[1] == t + 16'd1, "R8 table addresses",
            {rd_a[0], rd_a[1]}, {t, t + 16'd1});
        chk(ld_seen && ld_val == {memf(t + 16'd1), memf(t)}, "R8 loaded vector",
            ld_val, {memf(t + 16'd1), memf(t)});
      end
    end
    if (scr) chk(mode_o == ((m == 2'd1) ? 2'd2 : 2'd1), "R9 mode write during run landed",
                 mode_o, (m == 2'd1) ? 2'd2 : 2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mode_o == 0 && ie_o == 0, "R1 reset mode and enable", {mode_o, ie_o}, 0);
    chk({ack_o, push_req_o, mem_rd_o, pc_load_o, opcode_valid_o} == 0, "R1 strobes idle",
        {ack_o, push_req_o, mem_rd_o, pc_load_o, opcode_valid_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 mode and enable commands
    set_mode(2'd2);
    chk(mode_o == 2, "R2 mode write 2", mode_o, 2);
    set_mode(2'd3);
    chk(mode_o == 2, "R2 mode write 3 ignored", mode_o, 2);
    set_mode(2'd1);
    chk(mode_o == 1, "R2 mode write 1", mode_o, 1);
    enable();
    chk(ie_o == 1, "R2 enable set", ie_o, 1);
    @(negedge clk); ie_set = 1; ie_clr = 1;
    @(negedge clk); ie_set = 0; ie_clr = 0;
    chk(ie_o == 0, "R2 clear wins over set", ie_o, 0);

    // R3 gating: disabled, then no boundary
    clr_log();
    irq_req = 1;
    repeat (8) @(negedge clk);
    chk(nack == 0, "R3 no take while disabled", nack, 0);
    insn_bnd = 0;
    enable();
    repeat (8) @(negedge clk);
    chk(nack == 0 && ie_o == 1, "R3 no take off boundary", {nack[7:0], 7'd0, ie_o}, 16'h0001);
    insn_bnd = 1;
    repeat (12) @(negedge clk);
    chk(nack == 1, "R3 take at boundary", nack, 1);
    // R4 request still high, enable clear: nothing more
    repeat (20) @(negedge clk);
    chk(nack == 1 && ie_o == 0, "R4 no second take while disabled", nack, 1);
    irq_req = 0;
    repeat (4) @(negedge clk);

    // R4 set on the take edge loses to the take
    clr_log();
    set_mode(2'd0);
    enable();
    @(negedge clk); irq_req = 1; ie_set = 1;
    @(negedge clk); ie_set = 0; irq_req = 0;
    repeat (6) @(negedge clk);
    chk(nack == 1 && ie_o == 0, "R4 take beats same-edge set", {nack[7:0], 7'd0, ie_o}, 16'h0100);

    // R5 mode 0 sweep
    for (int k = 0; k < 32; k++)
      run_irq(2'd0, 8'(k * 37 + 5), 8'(k), 16'(k * 4099), 16'h9000, k % 3, 0);
    // R7 mode 1 sweep, device byte varies and is ignored
    for (int k = 0; k < 16; k++)
      run_irq(2'd1, 8'(k * 53), 8'(k * 11), 16'(k * 2311 + 1), 16'(16'h4000 + k * 17), k % 3, 0);
    // R8 mode 2 sweep across every device byte
    for (int k = 0; k < 256; k++)
      run_irq(2'd2, 8'(k), 8'(k * 7 + 3), {8'(k), ~8'(k)}, 16'(16'h8000 + k * 3), k % 3, 0);
    // R8 stack pointer wrap at zero
    run_irq(2'd2, 8'hFF, 8'h00, 16'hABCD, 16'h0001, 1, 0);
    // R9 inputs changed mid-sequence
    run_irq(2'd2, 8'h33, 8'h12, 16'h1234, 16'h7FF0, 2, 1);
    run_irq(2'd1, 8'hC7, 8'h40, 16'hBEEF, 16'h0100, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule